// File: doc/BRIEF.md
# Three-lane 7:1 serial deserializer

This block turns three serial data lanes into one 21-bit parallel word per frame. A slow frame clock travels beside the data lanes. The block runs on a bit clock at seven times the frame rate, and that clock comes from outside the block. The frame clock, data lanes and shutdown input are sampled on the bit clock. A rising frame-clock edge marks the first bit of each frame. After a frame's seventh bit arrives, the three seven-bit slices are moved together into a holding register that drives the parallel bus.

Along with each word the block produces a regenerated word clock. The word clock is high for four bit-clock cycles and low for three. The word only changes while this clock is low, so downstream logic can take the word on the falling edge. The word-valid flag stays low for a programmable number of words after reset or after shutdown is released. A sticky flag reports a frame edge that arrives at the wrong bit position. The active-low shutdown input clears all state and holds the word clock low.

Top module: `tri_lane_deser`

## Requirements
- R1: Lane 0 fills `word_out[6:0]`, lane 1 fills `word_out[13:7]` and lane 2 fills `word_out[20:14]`.
- R2: Within a frame, each lane carries the highest-numbered bit of its slice first and the lowest-numbered bit last.
- R3: A frame starts with the bit that is sampled on the same bit-clock edge where the frame clock is first seen high after being low.
- R4: All 21 bits of `word_out` change on a single bit-clock edge, one cycle after the edge that samples a frame's last bit. The word then holds until the next complete frame is captured.
- R5: Once the block is framed, `word_clk` is high for 4 bit-clock cycles and low for 3 in every frame, and `word_out` never changes while `word_clk` is high.
- R6: `word_valid` stays low for the first `SETTLE` words (default 4) captured after reset or shutdown release. It goes high when word `SETTLE`+1 is captured.
- R7: When `shdn_n` is sampled low, the next cycle shows `word_out` = 0, `word_clk` = 0, `word_valid` = 0 and `misalign` = 0. These values hold while `shdn_n` stays low, whatever the lanes and the frame clock do.
- R8: A frame-clock rising edge that arrives while the bit-slot count is not at slot 6 does three things: it sets `misalign`, which stays set until shutdown or reset; it restarts the frame at that bit; and it drops the partial word, so `word_out` keeps the last complete word.
- R9: The asynchronous reset `rst_n` gives the same cleared state as shutdown. `word_clk` stays low until the first frame-clock rising edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown: clears all state and holds the word clock low |
| frame_clk | input | 1 | Frame clock; a rising edge marks the first bit of a frame |
| lane_in | input | 3 | Serial data, one bit per lane |
| word_out | output | 21 | Assembled parallel word |
| word_clk | output | 1 | Regenerated word clock; the word is stable at its falling edge |
| word_valid | output | 1 | High once the settling words have passed |
| misalign | output | 1 | Sticky flag for a frame edge at an unexpected bit slot |

## Verification
Words with one lane's slice set, or with one bit set, show whether each lane feeds its own slice and whether the first serial bit lands on the highest bit rather than the lowest. All-ones, alternating and pseudo-random words confirm that all three slices update together. They also confirm that the word clock's high/low pattern stays fixed whatever the data. A four-bit short frame followed by full frames separates a correct realign-and-discard from a design that puts out the partial word or loses the next boundary. A shutdown in the middle of the stream, with lanes still toggling, shows that the cleared state holds and that the settling count starts again afterwards.

// File: rtl/tld_pkg.sv
package tld_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned TLD_LANES    = 3;
  localparam int unsigned TLD_LANE_W   = 7;
  localparam int unsigned TLD_CLK_HIGH = 4;
  localparam int unsigned TLD_SETTLE   = 4;

  // Width of a counter that must hold values 0 .. n-1 (at least one bit)
  function automatic int unsigned tld_cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tld_frame_edge.sv
module tld_frame_edge #(
  parameter int unsigned LANES = tld_pkg::TLD_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             frame_clk,
  input  logic [LANES-1:0] lane_in,
  output logic [LANES-1:0] lane_q,
  output logic             rise
);
  timeunit 1ns;
  timeprecision 1ps;

  logic             fc_q, fc_q_nxt;
  logic             fc_prev, fc_prev_nxt;
  logic [LANES-1:0] ln_nxt;

  // Sample the frame clock and the lanes together, so the first bit of a
  // frame is held in lane_q during the cycle in which rise is reported.
  always_comb begin
    fc_q_nxt    = frame_clk;
    fc_prev_nxt = fc_q;
    ln_nxt      = lane_in;
    if (clr) begin
      fc_q_nxt    = 1'b0;
      fc_prev_nxt = 1'b0;
      ln_nxt      = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q    <= 1'b0;
      fc_prev <= 1'b0;
      lane_q  <= '0;
    end else begin
      fc_q    <= fc_q_nxt;
      fc_prev <= fc_prev_nxt;
      lane_q  <= ln_nxt;
    end
  end

  assign rise = fc_q & ~fc_prev;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R3
endmodule

// File: rtl/tld_slot_track.sv
module tld_slot_track #(
  parameter int unsigned LANE_W   = tld_pkg::TLD_LANE_W,
  parameter int unsigned CLK_HIGH = tld_pkg::TLD_CLK_HIGH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rise,
  output logic cap_en,
  output logic word_clk,
  output logic misalign
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned SLOT_W = tld_pkg::tld_cw(LANE_W);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(LANE_W - 1);

  logic [SLOT_W-1:0] slot_r, slot_nxt, cur_slot;
  logic aligned_r, aligned_nxt;
  logic mis_r, mis_nxt;
  logic wclk_r, wclk_nxt;
  logic framed;

  // cur_slot is the slot of the bit currently held in the sampled lanes
  always_comb begin
    framed = aligned_r | rise;
    if (rise)
      cur_slot = '0;
    else if (slot_r == LAST)
      cur_slot = '0;
    else
      cur_slot = slot_r + 1'b1;

    slot_nxt    = cur_slot;
    aligned_nxt = framed;
    mis_nxt     = mis_r | (rise & aligned_r & (slot_r != LAST));
    wclk_nxt    = framed & (32'(cur_slot) < CLK_HIGH);
    cap_en      = framed & (cur_slot == LAST);

    if (clr) begin
      slot_nxt    = LAST;
      aligned_nxt = 1'b0;
      mis_nxt     = 1'b0;
      wclk_nxt    = 1'b0;
      cap_en      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_r    <= LAST;
      aligned_r <= 1'b0;
      mis_r     <= 1'b0;
      wclk_r    <= 1'b0;
    end else begin
      slot_r    <= slot_nxt;
      aligned_r <= aligned_nxt;
      mis_r     <= mis_nxt;
      wclk_r    <= wclk_nxt;
    end
  end

  assign word_clk = wclk_r;
  assign misalign = mis_r;

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    slot_r <= LAST); // R4
  AST_REALIGN_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr) |=> (slot_r == '0)); // R3
  AST_MISALIGN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_r && !clr) |=> mis_r); // R8
endmodule

// File: rtl/tld_lane_shift.sv
module tld_lane_shift #(
  parameter int unsigned LANE_W = tld_pkg::TLD_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              din,
  output logic [LANE_W-1:0] par
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [LANE_W-2:0] sh_r, sh_nxt;

  // The earliest bit of the frame ends up at the top of the slice
  always_comb begin
    sh_nxt = {sh_r[LANE_W-3:0], din};
    if (clr) sh_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_r <= '0;
    else        sh_r <= sh_nxt;
  end

  assign par = {sh_r, din};
endmodule

// File: rtl/tld_word_hold.sv
module tld_word_hold #(
  parameter int unsigned WORD_W = tld_pkg::TLD_LANES * tld_pkg::TLD_LANE_W,
  parameter int unsigned SETTLE = tld_pkg::TLD_SETTLE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_en,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out,
  output logic              valid
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CNT_W = tld_pkg::tld_cw(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SETTLE);

  logic [WORD_W-1:0] hold_r, hold_nxt;
  logic [CNT_W-1:0]  cnt_r, cnt_nxt;
  logic              valid_r, valid_nxt;

  always_comb begin
    hold_nxt  = hold_r;
    cnt_nxt   = cnt_r;
    valid_nxt = valid_r;
    if (cap_en) begin
      hold_nxt  = word_in;
      valid_nxt = (cnt_r == CNT_TOP);
      if (cnt_r != CNT_TOP) cnt_nxt = cnt_r + 1'b1;
    end
    if (clr) begin
      hold_nxt  = '0;
      cnt_nxt   = '0;
      valid_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_r  <= '0;
      cnt_r   <= '0;
      valid_r <= 1'b0;
    end else begin
      hold_r  <= hold_nxt;
      cnt_r   <= cnt_nxt;
      valid_r <= valid_nxt;
    end
  end

  assign word_out = hold_r;
  assign valid    = valid_r;

  AST_HOLD_ONLY_ON_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !clr) |=> $stable(hold_r)); // R4
  AST_VALID_ON_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_r) |-> $past(cap_en)); // R6
endmodule

// File: rtl/tri_lane_deser.sv
module tri_lane_deser #(
  parameter int unsigned LANES    = tld_pkg::TLD_LANES,
  parameter int unsigned LANE_W   = tld_pkg::TLD_LANE_W,
  parameter int unsigned CLK_HIGH = tld_pkg::TLD_CLK_HIGH,
  parameter int unsigned SETTLE   = tld_pkg::TLD_SETTLE
) (
  input  logic                    clk_bit,
  input  logic                    rst_n,
  input  logic                    shdn_n,
  input  logic                    frame_clk,
  input  logic [LANES-1:0]        lane_in,
  output logic [LANES*LANE_W-1:0] word_out,
  output logic                    word_clk,
  output logic                    word_valid,
  output logic                    misalign
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned WORD_W = LANES * LANE_W;

  logic              clr;
  logic [LANES-1:0]  lane_q;
  logic              rise;
  logic              cap_en;
  logic [WORD_W-1:0] word_bus;

  assign clr = ~shdn_n;

  tld_frame_edge #(.LANES(LANES)) u_edge (
    .clk(clk_bit), .rst_n(rst_n), .clr(clr), .frame_clk(frame_clk),
    .lane_in(lane_in), .lane_q(lane_q), .rise(rise)
  );

  tld_slot_track #(.LANE_W(LANE_W), .CLK_HIGH(CLK_HIGH)) u_slot (
    .clk(clk_bit), .rst_n(rst_n), .clr(clr), .rise(rise),
    .cap_en(cap_en), .word_clk(word_clk), .misalign(misalign)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tld_lane_shift #(.LANE_W(LANE_W)) u_shift (
      .clk(clk_bit), .rst_n(rst_n), .clr(clr), .din(lane_q[g]),
      .par(word_bus[g*LANE_W +: LANE_W])
    );
  end

  tld_word_hold #(.WORD_W(WORD_W), .SETTLE(SETTLE)) u_hold (
    .clk(clk_bit), .rst_n(rst_n), .clr(clr), .cap_en(cap_en),
    .word_in(word_bus), .word_out(word_out), .valid(word_valid)
  );

  AST_SHDN_CLEARS: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !shdn_n |=> (word_out == '0 && !word_clk && !word_valid && !misalign)); // R7
  AST_STABLE_WHILE_HIGH: assert property (@(posedge clk_bit) disable iff (!rst_n)
    word_clk |-> $stable(word_out)); // R5
endmodule

// File: tb/tri_lane_deser_bench.sv
module tri_lane_deser_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SETTLE = 4;

  logic        clk = 1'b0;
  logic        rst_n, shdn_n, frame_clk;
  logic [2:0]  lane_in;
  logic [20:0] word_out;
  logic        word_clk, word_valid, misalign;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [20:0] exp_word;
  int          caps;
  logic        mis_exp;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  tri_lane_deser u_tri_lane_deser (
    .clk_bit(clk), .rst_n(rst_n), .shdn_n(shdn_n), .frame_clk(frame_clk),
    .lane_in(lane_in), .word_out(word_out), .word_clk(word_clk),
    .word_valid(word_valid), .misalign(misalign)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Serialize one frame, top bit of each slice first; check the previous word
  task automatic send(input logic [20:0] w, input int nbits, input bit do_chk,
                      input string req);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      frame_clk = (i < (nbits + 1) / 2);
      for (int l = 0; l < 3; l++) lane_in[l] = w[l*7 + 6 - i];
      if (do_chk && i == 2) begin
        check(req, "word", 32'(word_out), 32'(exp_word));
        check("R5", "word_clk high", 32'(word_clk), 32'd1);
        check("R6", "valid", 32'(word_valid), 32'(caps >= SETTLE + 1));
        check("R8", "misalign", 32'(misalign), 32'(mis_exp));
      end
      if (do_chk && i == 6) begin
        check("R4", "word held", 32'(word_out), 32'(exp_word));
        check("R5", "word_clk low", 32'(word_clk), 32'd0);
      end
    end
    if (nbits == 7) begin
      exp_word = w;
      caps++;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; shdn_n = 1'b1; frame_clk = 1'b0; lane_in = '0;
    exp_word = '0; caps = 0; mis_exp = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "word in reset", 32'(word_out), 32'd0);
    check("R9", "valid in reset", 32'(word_valid), 32'd0);
    rst_n = 1'b1;
    lane_in = 3'b111;
    repeat (4) @(negedge clk);
    check("R9", "word_clk before first edge", 32'(word_clk), 32'd0);
    check("R9", "misalign after reset", 32'(misalign), 32'd0);
  endtask

  task automatic t_lane_map;
    send(21'h00007F, 7, 1, "R1");
    send(21'h003F80, 7, 1, "R1");
    send(21'h1FC000, 7, 1, "R1");
    send(21'h000000, 7, 1, "R1");
  endtask

  task automatic t_bit_order;
    send(21'h000001, 7, 1, "R2");
    send(21'h000040, 7, 1, "R2");
    send(21'h004000, 7, 1, "R2");
    send(21'h100000, 7, 1, "R2");
    send(21'h000080, 7, 1, "R2");
  endtask

  task automatic t_patterns;
    send(21'h1FFFFF, 7, 1, "R3");
    send(21'h155555, 7, 1, "R3");
    send(21'h0AAAAA, 7, 1, "R3");
    for (int k = 0; k < 6; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      send(lfsr[20:0], 7, 1, "R3");
    end
  endtask

  task automatic t_misalign;
    send(21'h0F0F0F, 7, 1, "R8");
    send(21'h1AAAAA, 4, 1, "R8");   // short frame, must be dropped
    mis_exp = 1'b1;
    send(21'h123456, 7, 1, "R8");   // still shows the last full word
    send(21'h0ABCDE, 7, 1, "R8");   // new boundary honoured
    send(21'h000000, 7, 1, "R8");
  endtask

  task automatic t_shutdown;
    @(negedge clk);
    shdn_n = 1'b0;
    @(negedge clk);
    check("R7", "word after shutdown", 32'(word_out), 32'd0);
    check("R7", "word_clk after shutdown", 32'(word_clk), 32'd0);
    check("R7", "valid after shutdown", 32'(word_valid), 32'd0);
    check("R7", "misalign after shutdown", 32'(misalign), 32'd0);
    send(21'h1FFFFF, 7, 0, "R7");
    send(21'h0F0F0F, 7, 0, "R7");
    check("R7", "word held clear", 32'(word_out), 32'd0);
    check("R7", "word_clk held low", 32'(word_clk), 32'd0);
    @(negedge clk);
    frame_clk = 1'b0;
    shdn_n = 1'b1;
    exp_word = '0; caps = 0; mis_exp = 1'b0;
    for (int k = 0; k < 7; k++) send(21'(32'h1111 * (k + 3)), 7, 1, "R6");
  endtask

  initial begin
    t_reset;
    t_lane_map;
    t_bit_order;
    t_patterns;
    t_misalign;
    t_shutdown;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule